// File: doc/BRIEF.md
# Two-Wire Output Enable Register Bank

This block is the slave side of a two-wire serial control bus for a six-pair differential clock fanout buffer. It watches a serial clock line and a serial data line, both pulled high when idle. It finds START and STOP conditions and shifts bits in on each rising edge of the serial clock. It acknowledges the bytes addressed to it by pulling the data line low for the ninth clock of each byte. A write transaction carries four kinds of byte, in this order:

- a 7-bit device address with a write flag;
- a command code byte;
- a byte count byte;
- the data bytes.

The data bytes fill a three-entry bank of 8-bit registers. Two registers hold per-pair output enables, spread over a sparse bit map. The third is a test register whose top bit selects a leakage-test mode. The block drives the six pair-enable bits and the test-mode bit straight to the output stage. A synchronous reset restores every register to its power-up value.

Top module: `oe_regbank`

## Requirements
- R1: After reset all six pair enables are 1 and `leak_test_o` is 0. The power-up values are 0xFF for register 0, 0xC0 for register 1 and 0xFF for register 2.
- R2: The block acknowledges a first byte only when bits 7..1 equal `DEV_ADDR` (default 0x69) and bit 0 (the read/write flag) is 0. Any other first byte gets no acknowledge, and no byte up to the next START or STOP is acknowledged or stored.
- R3: After the address, the first byte is the command code and the second is the byte count; both are acknowledged. Data bytes then go to register 0, 1 and 2 in turn, and at most byte-count of them are stored.
- R4: Register 0 drives five pairs: bit 7 drives pair 0, bit 6 drives pair 1, bit 3 drives pair 2, bit 2 drives pair 5 and bit 0 drives pair 4. A 1 enables the pair and a 0 disables it.
- R5: Bit 6 of register 1 drives pair 3, with the same encoding (1 enables, 0 disables).
- R6: `leak_test_o` is 1 exactly when bit 7 of register 2 is 0.
- R7: Data bytes past the byte count, or past register 2, are acknowledged but change nothing.
- R8: A START or STOP before a byte's eighth bit is complete discards that byte. Bytes already completed stay stored. After a START, a new address byte is expected.
- R9: Reserved bits are stored but do not change any output. Register 0 has reserved bits 5, 4 and 1; register 1 has reserved bits 7 and 5..0; register 2 has reserved bits 6..0.
- R10: Bits arrive most-significant first. The acknowledge pull starts while the serial clock is low after the eighth bit, holds through the ninth high phase, and ends after the ninth falling edge.
- R11: Asserting `rst` at any time restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| pair_en_o | output | 6 | Enable for each differential output pair, bit n is pair n |
| leak_test_o | output | 1 | 1 selects leakage-test mode |

## Verification
A wrong byte counter or phase shows up first on the bus. The acknowledge is missing or lands in the wrong slot, and the bench samples it in the middle of each ninth clock. That is within one byte time of the error.

A wrong register pointer or a wrong remaining count leaves the pair-enable pins in the wrong state. This is visible once the transaction's STOP has passed.

The chosen data patterns give each mapped bit its own value. A bit swapped between pairs, or a reserved bit leaking into an enable, therefore changes a specific pair-enable bit.

// File: rtl/oe_pkg.sv
package oe_pkg;

    localparam int NUM_REGS  = 3;
    localparam int REG_W     = 8;
    localparam int NUM_PAIRS = 6;
    localparam int PTR_W     = $clog2(NUM_REGS + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } phase_e;

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int pair_reg(input int pair);
        return (pair == 3) ? 1 : 0;
    endfunction

    function automatic int pair_bit(input int pair);
        case (pair)
            0:       return 7;
            1:       return 6;
            2:       return 3;
            3:       return 6;
            4:       return 0;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/oe_bus_sync.sv
module oe_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= d;
    end

    assign scl_o      = q.scl_pipe[STAGES-1];
    assign sda_o      = q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_o & q.scl_prev;
    assign start_o    = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & q.scl_prev & ~q.sda_prev & sda_o;

endmodule

// File: rtl/oe_byte_fsm.sv
module oe_byte_fsm
    import oe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             we_o,
    output logic [PTR_W-1:0] widx_o,
    output logic [REG_W-1:0] wdata_o,
    output logic             pull_o
);

    typedef struct packed {
        phase_e             phase;
        logic [3:0]         bitcnt;
        logic [REG_W-1:0]   shreg;
        logic               ack;
        logic [REG_W-1:0]   remain;
        logic [PTR_W-1:0]   ptr;
    } fsm_t;

    fsm_t q, d;
    logic we;

    always_comb begin
        d  = q;
        we = 1'b0;
        if (stop_i) begin
            d.phase  = PH_IDLE;
            d.bitcnt = '0;
            d.ack    = 1'b0;
        end else if (start_i) begin
            d.phase  = PH_ADDR;
            d.bitcnt = '0;
            d.ack    = 1'b0;
        end else if (scl_rise_i && !q.ack && q.bitcnt < 4'd8) begin
            d.shreg  = {q.shreg[REG_W-2:0], sda_i};
            d.bitcnt = q.bitcnt + 4'd1;
        end else if (scl_fall_i && q.ack) begin
            d.ack = 1'b0;
        end else if (scl_fall_i && q.bitcnt == 4'd8) begin
            d.bitcnt = '0;
            case (q.phase)
                PH_ADDR: begin
                    if (q.shreg[7:1] == DEV_ADDR && !q.shreg[0]) begin
                        d.ack   = 1'b1;
                        d.phase = PH_CMD;
                    end else begin
                        d.phase = PH_IDLE;
                    end
                end
                PH_CMD: begin
                    d.ack   = 1'b1;
                    d.phase = PH_CNT;
                end
                PH_CNT: begin
                    d.ack    = 1'b1;
                    d.remain = q.shreg;
                    d.ptr    = '0;
                    d.phase  = PH_DATA;
                end
                PH_DATA: begin
                    d.ack = 1'b1;
                    if (q.remain != '0) begin
                        d.remain = q.remain - 8'd1;
                        if (q.ptr < PTR_W'(NUM_REGS)) begin
                            we    = 1'b1;
                            d.ptr = q.ptr + PTR_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.phase  <= PH_IDLE;
            q.bitcnt <= '0;
            q.shreg  <= '0;
            q.ack    <= 1'b0;
            q.remain <= '0;
            q.ptr    <= '0;
        end else begin
            q <= d;
        end
    end

    assign we_o    = we;
    assign widx_o  = q.ptr;
    assign wdata_o = q.shreg;
    assign pull_o  = q.ack;

    // R10: the acknowledge pull only begins while the synchronized clock is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(q.ack) |-> !scl_i);

    // R8: a START releases the data line on the next cycle
    p_start_release_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !q.ack);

    // R8: a STOP releases the data line on the next cycle
    p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !q.ack);

endmodule

// File: rtl/oe_reg_file.sv
module oe_reg_file
    import oe_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we_i,
    input  logic [PTR_W-1:0]                 widx_i,
    input  logic [REG_W-1:0]                 wdata_i,
    output logic [NUM_REGS-1:0][REG_W-1:0]   regs_o
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (we_i && widx_i == PTR_W'(i)) regs_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    // R7: register contents only move when the sequencer issued a write
    p_change_needs_we_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_q) |-> $past(we_i));

endmodule

// File: rtl/oe_regbank.sv
module oe_regbank
    import oe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull_o,
    output logic [NUM_PAIRS-1:0] pair_en_o,
    output logic                 leak_test_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic                           we;
    logic [PTR_W-1:0]               widx;
    logic [REG_W-1:0]               wdata;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    oe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    oe_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .we_o       (we),
        .widx_o     (widx),
        .wdata_o    (wdata),
        .pull_o     (sda_pull_o)
    );

    oe_reg_file u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .widx_i  (widx),
        .wdata_i (wdata),
        .regs_o  (regs)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int RI = pair_reg(p);
        localparam int BI = pair_bit(p);
        assign pair_en_o[p] = regs[RI][BI];
    end

    assign leak_test_o = ~regs[2][7];

    // R1: output-stage controls are always driven to known levels
    p_outputs_known_r1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({pair_en_o, leak_test_o, sda_pull_o}));

endmodule

// File: tb/oe_regbank_test.sv
module oe_regbank_test;

    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [5:0] pair_en;
    logic       leak;
    wire        sda_bus = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    oe_regbank uut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .pair_en_o   (pair_en),
        .leak_test_o (leak)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(HALF);
        scl   = 1'b1; idle(HALF);
        sda_m = 1'b0; idle(HALF);
        scl   = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(HALF);
        scl   = 1'b1; idle(HALF);
        sda_m = 1'b1; idle(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; idle(HALF);
            scl   = 1'b1; idle(HALF);
            scl   = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        send_bits(b, 8);
        sda_m = 1'b1; idle(HALF);
        scl   = 1'b1; idle(HALF / 2);
        ack   = ~sda_bus;
        idle(HALF / 2);
        scl   = 1'b0; idle(6);
        rel   = sda_bus;
    endtask

    task automatic write_txn(input logic [7:0] cnt, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input logic [7:0] d3, input logic [7:0] d4,
                             input int n, input string tag);
        logic ack, rel;
        logic [7:0] dat [5];
        dat = '{d0, d1, d2, d3, d4};
        bus_start();
        send_byte(8'hD2, ack, rel);
        chk(ack, 1, {tag, " R2 address ack"});
        chk(rel, 1, {tag, " R10 release after ninth clock"});
        send_byte(8'h00, ack, rel);
        chk(ack, 1, {tag, " R3 command ack"});
        send_byte(cnt, ack, rel);
        chk(ack, 1, {tag, " R3 count ack"});
        for (int i = 0; i < n; i++) begin
            send_byte(dat[i], ack, rel);
            chk(ack, 1, {tag, " R7 data ack"});
        end
        bus_stop();
        idle(4);
    endtask

    task automatic t_reset_defaults();
        chk(pair_en, 6'h3F, "R1 pair enables after reset");
        chk(leak, 0, "R1 test mode after reset");
        chk(sda_pull, 0, "R1 bus released after reset");
    endtask

    task automatic t_basic_write();
        write_txn(8'd3, 8'h41, 8'h00, 8'h7F, 8'h00, 8'h00, 3, "basic");
        chk(pair_en, 6'h12, "R4 R5 basic map 0x41/0x00");
        chk(leak, 1, "R6 leak test selected");
    endtask

    task automatic t_map();
        write_txn(8'd2, 8'h88, 8'h40, 8'h00, 8'h00, 8'h00, 2, "map");
        chk(pair_en, 6'h0D, "R4 R5 pairs 0,2,3");
        chk(leak, 1, "R3 count limits writes, reg2 kept");
        write_txn(8'd1, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 1, "map2");
        chk(pair_en, 6'h28, "R4 bit2 drives pair5");
    endtask

    task automatic t_reserved();
        write_txn(8'd2, 8'h36, 8'hFF, 8'h00, 8'h00, 8'h00, 2, "resv");
        chk(pair_en, 6'h28, "R9 reserved bits no effect");
        chk(leak, 1, "R9 leak unchanged");
    endtask

    task automatic t_overflow();
        write_txn(8'd5, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 5, "ovf");
        chk(pair_en, 6'h3F, "R7 bytes past reg2 discarded");
        chk(leak, 0, "R7 reg2 kept 0xFF");
        write_txn(8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2, "ovf2");
        chk(pair_en, 6'h08, "R7 byte past count discarded");
    endtask

    task automatic t_bad_addr();
        logic ack, rel;
        bus_start();
        send_byte(8'hD4, ack, rel);
        chk(ack, 0, "R2 wrong address no ack");
        send_byte(8'h00, ack, rel);
        send_byte(8'h01, ack, rel);
        send_byte(8'hFF, ack, rel);
        chk(ack, 0, "R2 ignored data no ack");
        bus_stop();
        idle(4);
        chk(pair_en, 6'h08, "R2 wrong address no write");
        bus_start();
        send_byte(8'hD3, ack, rel);
        chk(ack, 0, "R2 read flag no ack");
        send_byte(8'h00, ack, rel);
        send_byte(8'h01, ack, rel);
        send_byte(8'hFF, ack, rel);
        bus_stop();
        idle(4);
        chk(pair_en, 6'h08, "R2 read flag no write");
    endtask

    task automatic t_abort();
        logic ack, rel;
        write_txn(8'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2, "abort0");
        chk(pair_en, 6'h00, "R8 setup all off");
        bus_start();
        send_byte(8'hD2, ack, rel);
        send_byte(8'h00, ack, rel);
        send_byte(8'h02, ack, rel);
        send_byte(8'hFF, ack, rel);
        send_bits(8'hFF, 4);
        bus_stop();
        idle(4);
        chk(pair_en, 6'h37, "R8 stop mid byte keeps earlier byte only");
        bus_start();
        send_byte(8'hD2, ack, rel);
        send_byte(8'h00, ack, rel);
        send_byte(8'h01, ack, rel);
        send_bits(8'h00, 4);
        bus_start();
        send_byte(8'hD2, ack, rel);
        chk(ack, 1, "R8 address after restart acked");
        send_byte(8'h00, ack, rel);
        send_byte(8'h01, ack, rel);
        send_byte(8'h80, ack, rel);
        bus_stop();
        idle(4);
        chk(pair_en, 6'h01, "R8 start mid byte then new write");
    endtask

    task automatic t_reset_mid();
        write_txn(8'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3, "rst");
        chk(pair_en, 6'h00, "R11 setup all off");
        chk(leak, 1, "R11 setup leak on");
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        chk(pair_en, 6'h3F, "R11 reset restores enables");
        chk(leak, 0, "R11 reset restores test off");
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(5);
        t_reset_defaults();
        t_basic_write();
        t_map();
        t_reserved();
        t_overflow();
        t_bad_addr();
        t_abort();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule